// File: doc/BRIEF.md
# ISA Extension Register with Compressed-Subset Enables

This block holds the machine-mode register with one bit per single-letter instruction-set extension. Bit n stands for letter 'A'+n. Software writes the register through a write strobe and a data word. Two static inputs shape each write: a writable-bit mask and the vector of extensions the implementation supports.

Extension bits that depend on one another are cleared by the block before the write is merged. A write that would drop compressed support is refused while the program counter is only 2-byte aligned.

From the register value the block derives registered enable flags for the compressed-instruction subsets:
- base
- single-float
- double-float
- bit-manipulation
- push/pop
- table-jump

Each flag is limited by a static per-subset support vector. A one-cycle accept pulse reports whether a write took effect.

Top module: `isa_ext_reg`

## Requirements
- R1: Under the synchronous active-low reset, the register loads the supported-extension vector, the accept flag is low, and the enables take the values derived from that vector by R7 to R9.
- R2: A write is refused when all three of these hold: bit 2 (C) of the write data is 0, bit 2 of the current register is 1, and the PC bit-1 input is 1. A refused write leaves the register and all enables unchanged, and the accept flag is low in the next cycle.
- R3: Any other write is accepted. The register and enables update on that clock edge, and the accept flag is high for exactly the following cycle.
- R4: When bit 5 (F) of the write data is 0, bit 3 (D) of the data is forced to 0 before merging.
- R5: When the D bit left after R4 is 0, bit 16 (Q) and bit 21 (V) of the data are forced to 0. A cleared F therefore cascades to D, Q and V.
- R6: An accepted write stores (adjusted data AND mask) OR (old value AND NOT mask). Bits outside the mask never change.
- R7: The base compressed enable is (new C bit OR C not supported) AND subset-support bit 0.
- R8: The single-float enable is the new F bit AND the base enable AND support bit 1. The double-float enable is the new D bit AND the base enable AND support bit 2.
- R9: The bit-manipulation, push/pop and table-jump enables each equal the base enable AND support bits 3, 4 and 5 respectively.
- R10: Without a write strobe, the register and enables hold and the accept flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrData | input | 26 | Write data, one bit per letter |
| pcBit1 | input | 1 | Bit 1 of the current program counter |
| wrMask | input | 26 | Static writable-bit mask |
| supportVec | input | 26 | Static supported-letter vector, also the reset value |
| subSupport | input | 6 | Static subset support: base, float, double, bitmanip, push/pop, table-jump |
| isaValue | output | 26 | Current register value |
| wrAccept | output | 1 | High for one cycle after an accepted write |
| enCBase | output | 1 | Compressed base enable |
| enCFloat | output | 1 | Compressed single-float enable |
| enCDouble | output | 1 | Compressed double-float enable |
| enCBitm | output | 1 | Compressed bit-manipulation enable |
| enCPushPop | output | 1 | Compressed push/pop enable |
| enCTableJump | output | 1 | Compressed table-jump enable |

## Verification
The refusal case is the hardest to reach. It needs C already set, a write that clears it, and PC bit 1 high all at once. The stimulus sends the same C-clearing word twice: first with bit 1 high, where it must be refused, then with bit 1 low, where it must be accepted. A third write with C already clear and bit 1 high must be accepted. The bench also resets under a support vector without C, so that the base enable must be high while the C bit is clear.

// File: rtl/isa_ext_pkg.sv
package isa_ext_pkg;
  localparam int LETTERS = 26;
  localparam int NSUB    = 6;

  localparam int BIT_C = 2;
  localparam int BIT_D = 3;
  localparam int BIT_F = 5;
  localparam int BIT_Q = 16;
  localparam int BIT_V = 21;

  localparam int SUB_BASE  = 0;
  localparam int SUB_FLT   = 1;
  localparam int SUB_DBL   = 2;
  localparam int SUB_BITM  = 3;
  localparam int SUB_PUSH  = 4;
  localparam int SUB_TABLE = 5;

  typedef struct packed {
    logic load;
    logic refuse;
  } ctlStrobe_t;
endpackage

// File: rtl/isa_ext_ctl.sv
module isa_ext_ctl
  import isa_ext_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrDataC,
  input  logic       curC,
  input  logic       pcBit1,
  output ctlStrobe_t strobe,
  output logic       wrAccept
);
  logic dropsC;

  always_comb begin
    dropsC        = !wrDataC && curC;
    strobe.refuse = wrEn && dropsC && pcBit1;
    strobe.load   = wrEn && !strobe.refuse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrAccept <= 1'b0;
    else       wrAccept <= strobe.load;
  end

  // R2: a refused write never raises the accept flag
  a_r2_refuse_misaligned: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrDataC && curC && pcBit1) |=> !wrAccept);

  // R3 and R10: the accept flag only follows a strobed write
  a_r3_accept_after_write: assert property (@(posedge clk) disable iff (!rstN)
    wrAccept |-> $past(wrEn));
endmodule

// File: rtl/isa_ext_dp.sv
module isa_ext_dp
  import isa_ext_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [LETTERS-1:0] wrData,
  input  logic [LETTERS-1:0] wrMask,
  input  logic [LETTERS-1:0] supportVec,
  input  logic [NSUB-1:0]    subSupport,
  output logic [LETTERS-1:0] isaValue,
  output logic [NSUB-1:0]    enVec
);
  logic [LETTERS-1:0] isaReg;
  logic [LETTERS-1:0] adjData;
  logic [LETTERS-1:0] mergedVal;
  logic [NSUB-1:0]    enReg;
  logic [NSUB-1:0]    enNext;
  logic [NSUB-1:0]    enReset;

  function automatic logic [NSUB-1:0] deriveEn(input logic [LETTERS-1:0] v,
                                                input logic [LETTERS-1:0] sup,
                                                input logic [NSUB-1:0]    subSup);
    logic [NSUB-1:0] e;
    logic base;
    base         = (v[BIT_C] || !sup[BIT_C]) && subSup[SUB_BASE];
    e[SUB_BASE]  = base;
    e[SUB_FLT]   = v[BIT_F] && base && subSup[SUB_FLT];
    e[SUB_DBL]   = v[BIT_D] && base && subSup[SUB_DBL];
    e[SUB_BITM]  = base && subSup[SUB_BITM];
    e[SUB_PUSH]  = base && subSup[SUB_PUSH];
    e[SUB_TABLE] = base && subSup[SUB_TABLE];
    return e;
  endfunction

  always_comb begin
    adjData = wrData;
    if (!adjData[BIT_F]) adjData[BIT_D] = 1'b0;
    if (!adjData[BIT_D]) begin
      adjData[BIT_Q] = 1'b0;
      adjData[BIT_V] = 1'b0;
    end
    mergedVal = (adjData & wrMask) | (isaReg & ~wrMask);
    enNext    = deriveEn(mergedVal, supportVec, subSupport);
    enReset   = deriveEn(supportVec, supportVec, subSupport);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isaReg <= supportVec;
      enReg  <= enReset;
    end else if (strobe.load) begin
      isaReg <= mergedVal;
      enReg  <= enNext;
    end
  end

  assign isaValue = isaReg;
  assign enVec    = enReg;

  // R2 and R10: without a load, the state holds
  a_r10_hold_state: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(isaReg) && $stable(enReg)));

  // R6: bits outside the writable mask never move
  a_r6_mask_protects: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((isaReg ^ $past(isaReg)) & ~wrMask) == '0));

  // R4: clearing F in written data clears a writable D
  a_r4_f_clears_d: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !wrData[BIT_F] && wrMask[BIT_D]) |=> !isaReg[BIT_D]);

  // R5: a writable Q never ends up set after a load that leaves D clear
  a_r5_d_clears_q: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !wrData[BIT_D] && wrMask[BIT_Q]) |=> !isaReg[BIT_Q]);
endmodule

// File: rtl/isa_ext_reg.sv
module isa_ext_reg
  import isa_ext_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [LETTERS-1:0] wrData,
  input  logic               pcBit1,
  input  logic [LETTERS-1:0] wrMask,
  input  logic [LETTERS-1:0] supportVec,
  input  logic [NSUB-1:0]    subSupport,
  output logic [LETTERS-1:0] isaValue,
  output logic               wrAccept,
  output logic               enCBase,
  output logic               enCFloat,
  output logic               enCDouble,
  output logic               enCBitm,
  output logic               enCPushPop,
  output logic               enCTableJump
);
  ctlStrobe_t      strobe;
  logic [NSUB-1:0] enVec;

  isa_ext_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrDataC  (wrData[BIT_C]),
    .curC     (isaValue[BIT_C]),
    .pcBit1   (pcBit1),
    .strobe   (strobe),
    .wrAccept (wrAccept)
  );

  isa_ext_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .wrMask     (wrMask),
    .supportVec (supportVec),
    .subSupport (subSupport),
    .isaValue   (isaValue),
    .enVec      (enVec)
  );

  assign enCBase      = enVec[SUB_BASE];
  assign enCFloat     = enVec[SUB_FLT];
  assign enCDouble    = enVec[SUB_DBL];
  assign enCBitm      = enVec[SUB_BITM];
  assign enCPushPop   = enVec[SUB_PUSH];
  assign enCTableJump = enVec[SUB_TABLE];
endmodule

// File: tb/sim_isa_ext_reg.sv
`timescale 1ns/1ps
module sim_isa_ext_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [25:0] wrData = '0;
  logic        pcBit1 = 1'b0;
  logic [25:0] wrMask = '0;
  logic [25:0] supportVec = '0;
  logic [5:0]  subSupport = '0;
  logic [25:0] isaValue;
  logic        wrAccept, enCBase, enCFloat, enCDouble, enCBitm, enCPushPop, enCTableJump;

  int   nRun = 0;
  int   nFail = 0;
  bit   finished = 0;

  logic [25:0] refReg;
  logic        refAcc;
  logic [5:0]  refEn;

  always #2.5 clk = ~clk;

  isa_ext_reg u0 (.*);

  function automatic logic [5:0] refDerive(input logic [25:0] v);
    logic b;
    b = (v[2] || !supportVec[2]) && subSupport[0];
    return {b && subSupport[5], b && subSupport[4], b && subSupport[3],
            v[3] && b && subSupport[2], v[5] && b && subSupport[1], b};
  endfunction

  task automatic chk(input string tag, input string what, input logic [25:0] act, input logic [25:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "isaValue", isaValue, refReg);
    chk(tag, "wrAccept", {25'b0, wrAccept}, {25'b0, refAcc});
    chk(tag, "enables",
        {20'b0, enCTableJump, enCPushPop, enCBitm, enCDouble, enCFloat, enCBase},
        {20'b0, refEn});
  endtask

  task automatic doReset(input logic [25:0] sup, input logic [25:0] msk, input logic [5:0] sub);
    rstN = 1'b0; supportVec = sup; wrMask = msk; subSupport = sub; wrEn = 1'b0;
    @(posedge clk); @(posedge clk);
    refReg = sup; refAcc = 1'b0; refEn = refDerive(sup);
    @(negedge clk); rstN = 1'b1;
    compareAll("R1");
  endtask

  task automatic step(input string tag, input logic we, input logic [25:0] d, input logic p1);
    logic [25:0] adj;
    wrEn = we; wrData = d; pcBit1 = p1;
    @(posedge clk);
    if (we && !(!d[2] && refReg[2] && p1)) begin
      adj = d;
      if (!adj[5]) adj[3] = 1'b0;
      if (!adj[3]) begin adj[16] = 1'b0; adj[21] = 1'b0; end
      refReg = (adj & wrMask) | (refReg & ~wrMask);
      refEn  = refDerive(refReg);
      refAcc = 1'b1;
    end else refAcc = 1'b0;
    @(negedge clk);
    compareAll(tag);
    wrEn = 1'b0;
  endtask

  localparam logic [25:0] SUPA = 26'h0213_1AD;
  localparam logic [25:0] ALL  = 26'h3FF_FFFF;

  initial begin
    // phase A: C supported; the I bit (8) is outside the mask
    doReset(SUPA, SUPA & ~26'h100, 6'b111111);
    step("R10", 1'b0, 26'h0, 1'b0);
    step("R2", 1'b1, SUPA & ~26'h4, 1'b1);
    chk("R2", "C kept", {25'b0, isaValue[2]}, 26'h1);
    chk("R2", "no accept", {25'b0, wrAccept}, 26'h0);
    step("R3", 1'b1, SUPA & ~26'h4, 1'b0);
    chk("R7", "base off", {25'b0, enCBase}, 26'h0);
    chk("R8", "float off", {25'b0, enCFloat}, 26'h0);
    step("R10", 1'b0, 26'h0, 1'b0);
    step("R3", 1'b1, SUPA & ~26'h4, 1'b1);
    chk("R3", "accept with C already clear", {25'b0, wrAccept}, 26'h1);
    step("R9", 1'b1, SUPA, 1'b1);
    chk("R9", "push/pop on", {25'b0, enCPushPop}, 26'h1);
    step("R4", 1'b1, SUPA & ~26'h20, 1'b0);
    chk("R5", "D,Q,V cascade clear",
        {23'b0, isaValue[21], isaValue[16], isaValue[3]}, 26'h0);
    step("R5", 1'b1, SUPA & ~26'h8, 1'b0);
    chk("R5", "F kept, Q,V clear",
        {23'b0, isaValue[21], isaValue[16], isaValue[5]}, 26'h1);
    step("R8", 1'b1, ALL, 1'b0);
    chk("R8", "double on", {25'b0, enCDouble}, 26'h1);
    step("R6", 1'b1, 26'h4, 1'b0);
    chk("R6", "I bit held", {25'b0, isaValue[8]}, 26'h1);
    step("R10", 1'b0, ALL, 1'b1);

    // phase B: C unsupported, double subset unsupported
    doReset(SUPA & ~26'h4, SUPA & ~26'h4, 6'b111011);
    chk("R7", "base on without C", {25'b0, enCBase}, 26'h1);
    chk("R9", "double unsupported", {25'b0, enCDouble}, 26'h0);
    step("R8", 1'b1, ALL, 1'b1);
    step("R4", 1'b1, 26'h0, 1'b0);

    // phase C: base subset unsupported
    doReset(SUPA, SUPA, 6'b111110);
    chk("R9", "all off", {20'b0, enCTableJump, enCPushPop, enCBitm, enCDouble, enCFloat, enCBase}, 26'h0);
    step("R7", 1'b1, ALL, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule